// File: doc/BRIEF.md
# External Inquire Snoop Responder

This block answers coherence inquiries that system logic drives into a split instruction/data cache. A single inquiry carries a physical address and an invalidate qualifier. The block looks the line up at the same time in a physical-tag copy of the instruction cache, in a physical-tag copy of the data cache, and in the writeback buffers. It reports either a plain hit or a hit on modified data. It then updates the line state. Because the lookup uses its own tag copies, it never competes with the processor's linear-tag accesses.

A clean hit with the qualifier low leaves the line shared. A clean hit with the qualifier high invalidates it. Modified data, whether in a data-cache line or in a writeback buffer, must go back to memory first. For that data the block raises a valid/ready writeback request and holds the hit-modified response until the writeback completes. Only then does the final state change happen. The cache's own line fills and its evictions into the writeback buffers reach the block through plain control ports.

Top module: `inq_snoop_responder`

## Requirements
- R1: An inquiry is accepted when `inq_strobe` is high and `busy` is low at a clock edge. `rsp_valid` pulses for one cycle exactly two cycles later. `rsp_hit` and `rsp_hitm` are valid in that cycle and are never high together.
- R2: An address splits into three fields. The low `OFS_W` bits are ignored. The next log2(`SETS`) bits are the set index. The rest is the tag. Line states are encoded 00 invalid, 01 shared, 10 exclusive and 11 modified. `rsp_hit` is raised when the tag matches a data line in state 01 or 10, or an instruction line in any state other than 00.
- R3: `rsp_hitm` is raised when the tag matches a data line in state 11, or when the line address matches a valid writeback-buffer entry. `rsp_hit` is then suppressed, even if the instruction cache also matches.
- R4: With `inq_inv` low, a clean matching data line ends in state 01, and a matching instruction line is left unchanged.
- R5: With `inq_inv` high, the matching clean data line and the matching instruction line are invalidated in the response cycle.
- R6: A hit-modified response also raises `wb_req_valid`. `wb_req_addr` carries the line address with the offset bits zero. Both stay stable until a cycle with `wb_req_ready` high. `wb_done` has no effect before that handshake.
- R7: `rsp_hitm` stays high until `wb_done` is seen after the handshake. At that edge a matching modified data line becomes 01 if `inq_inv` was low, or 00 if it was high. Writeback-buffer entries with that line address are released in either case.
- R8: `busy` is high from acceptance until the response cycle, or until writeback completion for a hit-modified response. Strobes while `busy` is high produce no response.
- R9: `fill_en` writes a tag and state into the data array (`fill_dside` high) or the instruction array. When a fill and a snoop state update address the same array and set in one cycle, the fill wins. The response still reflects the contents before the fill.
- R10: `wbuf_push` places a line address in the lowest free buffer slot. The push is dropped when all `NWB` slots are full. Each bit of `wbuf_clr` frees the slot with that index.
- R11: After reset every line is invalid, the writeback buffers are empty, and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inq_strobe | input | 1 | Inquiry strobe |
| inq_addr | input | AW | Inquiry physical address |
| inq_inv | input | 1 | Invalidate qualifier |
| rsp_valid | output | 1 | Response cycle marker |
| rsp_hit | output | 1 | Clean hit |
| rsp_hitm | output | 1 | Hit on modified data, held until writeback completes |
| busy | output | 1 | Inquiry in progress |
| fill_en | input | 1 | Tag-copy fill strobe |
| fill_dside | input | 1 | Fill targets the data array (1) or the instruction array (0) |
| fill_addr | input | AW | Fill line address |
| fill_state | input | 2 | Fill line state |
| wbuf_push | input | 1 | Writeback-buffer entry allocate |
| wbuf_addr | input | AW | Address for the allocated entry |
| wbuf_clr | input | NWB | Per-slot release mask |
| wb_req_valid | output | 1 | Writeback request valid |
| wb_req_ready | input | 1 | Writeback request accepted |
| wb_req_addr | output | AW | Writeback line address |
| wb_done | input | 1 | Writeback completed |

## Verification
Two functions can fall in the same cycle: a fill from the cache, and the inquiry's own state update to the same set of the data array. The bench provokes this by driving a fill of a new tag into the set under inquiry in the very cycle the response is formed. Three observations judge the outcome. The response must still report the old line. A later inquiry to the new tag must hit. A later inquiry to the old tag must miss.

// File: rtl/snoop_pkg.sv
`timescale 1ns/1ps
package snoop_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_SHR = 2'b01,
    LS_EXC = 2'b10,
    LS_MOD = 2'b11
  } line_st_t;
endpackage

// File: rtl/snp_tag_array.sv
`timescale 1ns/1ps
module snp_tag_array
  import snoop_pkg::*;
#(
  parameter int SETS = 16,
  parameter int TW   = 23,
  localparam int IW  = $clog2(SETS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_idx,
  output logic [TW-1:0] rd_tag,
  output line_st_t      rd_state,
  input  logic          fill_en,
  input  logic [IW-1:0] fill_idx,
  input  logic [TW-1:0] fill_tag,
  input  line_st_t      fill_state,
  input  logic          upd_en,
  input  line_st_t      upd_state
);
  logic [TW-1:0] tag_q [SETS];
  line_st_t      st_q  [SETS];

  assign rd_tag   = tag_q[rd_idx];
  assign rd_state = st_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        tag_q[s] <= '0;
        st_q[s]  <= LS_INV;
      end
    end else begin
      // a fill into the same set replaces the line the update referred to
      if (upd_en && !(fill_en && fill_idx == rd_idx))
        st_q[rd_idx] <= upd_state;
      if (fill_en) begin
        tag_q[fill_idx] <= fill_tag;
        st_q[fill_idx]  <= fill_state;
      end
    end
  end
endmodule

// File: rtl/snp_wbuf.sv
`timescale 1ns/1ps
module snp_wbuf #(
  parameter int NWB = 4,
  parameter int LW  = 27,
  localparam int SW = (NWB > 1) ? $clog2(NWB) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push_en,
  input  logic [LW-1:0]  push_line,
  input  logic [NWB-1:0] clr_mask,
  input  logic           rel_en,
  input  logic [LW-1:0]  rel_line,
  input  logic [LW-1:0]  look_line,
  output logic           look_hit
);
  logic [NWB-1:0] vld_q;
  logic [LW-1:0]  line_q [NWB];
  logic [NWB-1:0] look_m, rel_m;
  logic           have_free;
  logic [SW-1:0]  free_idx;

  for (genvar g = 0; g < NWB; g++) begin : g_cmp
    assign look_m[g] = vld_q[g] && (line_q[g] == look_line);
    assign rel_m[g]  = vld_q[g] && (line_q[g] == rel_line);
  end

  assign look_hit = |look_m;

  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    for (int i = NWB - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        have_free = 1'b1;
        free_idx  = SW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < NWB; i++) line_q[i] <= '0;
    end else begin
      for (int i = 0; i < NWB; i++)
        if (clr_mask[i] || (rel_en && rel_m[i])) vld_q[i] <= 1'b0;
      if (push_en && have_free) begin
        vld_q[free_idx]  <= 1'b1;
        line_q[free_idx] <= push_line;
      end
    end
  end
endmodule

// File: rtl/inq_snoop_responder.sv
`timescale 1ns/1ps
module inq_snoop_responder
  import snoop_pkg::*;
#(
  parameter int AW    = 32,
  parameter int OFS_W = 5,
  parameter int SETS  = 16,
  parameter int NWB   = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           inq_strobe,
  input  logic [AW-1:0]  inq_addr,
  input  logic           inq_inv,
  output logic           rsp_valid,
  output logic           rsp_hit,
  output logic           rsp_hitm,
  output logic           busy,
  input  logic           fill_en,
  input  logic           fill_dside,
  input  logic [AW-1:0]  fill_addr,
  input  logic [1:0]     fill_state,
  input  logic           wbuf_push,
  input  logic [AW-1:0]  wbuf_addr,
  input  logic [NWB-1:0] wbuf_clr,
  output logic           wb_req_valid,
  input  logic           wb_req_ready,
  output logic [AW-1:0]  wb_req_addr,
  input  logic           wb_done
);
  localparam int IW = $clog2(SETS);
  localparam int LW = AW - OFS_W;
  localparam int TW = LW - IW;

  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_WREQ, ST_WAIT} phase_t;

  phase_t        phase_q;
  logic [LW-1:0] s1_line;
  logic          s1_inv;
  logic [IW-1:0] s1_idx;
  logic [TW-1:0] s1_tag;

  logic [TW-1:0] d_tag, i_tag;
  line_st_t      d_st, i_st;
  logic          d_match, d_mod, i_match, wb_hit;
  logic          any_m, any_h;
  logic          d_upd_en, i_upd_en, rel_en;
  line_st_t      d_upd_st;
  logic          unused_low_bits;

  assign unused_low_bits = ^{inq_addr[OFS_W-1:0], fill_addr[OFS_W-1:0], wbuf_addr[OFS_W-1:0]};

  assign s1_idx = s1_line[IW-1:0];
  assign s1_tag = s1_line[LW-1:IW];

  snp_tag_array #(.SETS(SETS), .TW(TW)) u_dtags (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(s1_idx), .rd_tag(d_tag), .rd_state(d_st),
    .fill_en(fill_en && fill_dside),
    .fill_idx(fill_addr[OFS_W +: IW]), .fill_tag(fill_addr[AW-1 -: TW]),
    .fill_state(line_st_t'(fill_state)),
    .upd_en(d_upd_en), .upd_state(d_upd_st)
  );

  snp_tag_array #(.SETS(SETS), .TW(TW)) u_itags (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(s1_idx), .rd_tag(i_tag), .rd_state(i_st),
    .fill_en(fill_en && !fill_dside),
    .fill_idx(fill_addr[OFS_W +: IW]), .fill_tag(fill_addr[AW-1 -: TW]),
    .fill_state(line_st_t'(fill_state)),
    .upd_en(i_upd_en), .upd_state(LS_INV)
  );

  snp_wbuf #(.NWB(NWB), .LW(LW)) u_wbuf (
    .clk(clk), .rst_n(rst_n),
    .push_en(wbuf_push), .push_line(wbuf_addr[AW-1:OFS_W]),
    .clr_mask(wbuf_clr),
    .rel_en(rel_en), .rel_line(s1_line),
    .look_line(s1_line), .look_hit(wb_hit)
  );

  // lookup results, held stable while the inquiry is outstanding
  assign d_match = (d_st != LS_INV) && (d_tag == s1_tag);
  assign d_mod   = d_match && (d_st == LS_MOD);
  assign i_match = (i_st != LS_INV) && (i_tag == s1_tag);
  assign any_m   = d_mod || wb_hit;
  assign any_h   = (d_match && !d_mod) || i_match;

  // clean lines change at the response; modified lines after the writeback
  assign rel_en   = (phase_q == ST_WAIT) && wb_done;
  assign d_upd_en = ((phase_q == ST_LOOK) && d_match && !d_mod) || (rel_en && d_mod);
  assign d_upd_st = s1_inv ? LS_INV : LS_SHR;
  assign i_upd_en = (phase_q == ST_LOOK) && i_match && s1_inv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= ST_IDLE;
      s1_line   <= '0;
      s1_inv    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_hitm  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      unique case (phase_q)
        ST_IDLE: if (inq_strobe) begin
          s1_line <= inq_addr[AW-1:OFS_W];
          s1_inv  <= inq_inv;
          phase_q <= ST_LOOK;
        end
        ST_LOOK: begin
          rsp_valid <= 1'b1;
          rsp_hit   <= any_h && !any_m;
          rsp_hitm  <= any_m;
          phase_q   <= any_m ? ST_WREQ : ST_IDLE;
        end
        ST_WREQ: if (wb_req_ready) phase_q <= ST_WAIT;
        ST_WAIT: if (wb_done) begin
          rsp_hitm <= 1'b0;
          phase_q  <= ST_IDLE;
        end
        default: phase_q <= ST_IDLE;
      endcase
    end
  end

  assign busy         = (phase_q != ST_IDLE);
  assign wb_req_valid = (phase_q == ST_WREQ);
  assign wb_req_addr  = {s1_line, {OFS_W{1'b0}}};
endmodule

// File: rtl/inq_snoop_checker.sv
`timescale 1ns/1ps
module inq_snoop_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          inq_strobe,
  input logic          busy,
  input logic          rsp_valid,
  input logic          rsp_hit,
  input logic          rsp_hitm,
  input logic          wb_req_valid,
  input logic          wb_req_ready,
  input logic [AW-1:0] wb_req_addr,
  input logic          wb_done
);
  a_r1_rsp_after_two: assert property (@(posedge clk) disable iff (!rst_n)
    (inq_strobe && !busy) |=> ##1 rsp_valid);

  a_r1_rsp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(inq_strobe && !busy, 2));

  a_r1_hit_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_hitm));

  a_r3_hitm_at_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_hitm) |-> rsp_valid);

  a_r6_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req_valid && !wb_req_ready) |=> (wb_req_valid && $stable(wb_req_addr)));

  a_r7_hitm_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hitm && !wb_done) |=> rsp_hitm);

  a_r8_busy_while_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req_valid || rsp_hitm) |-> busy);
endmodule

bind inq_snoop_responder inq_snoop_checker #(.AW(AW)) u_inq_chk (
  .clk(clk), .rst_n(rst_n), .inq_strobe(inq_strobe), .busy(busy),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_hitm(rsp_hitm),
  .wb_req_valid(wb_req_valid), .wb_req_ready(wb_req_ready),
  .wb_req_addr(wb_req_addr), .wb_done(wb_done)
);

// File: tb/test_inq_snoop_responder.sv
`timescale 1ns/1ps
module test_inq_snoop_responder;
  localparam int AW = 32, OFS = 5, SETS = 16, NWB = 4;
  localparam int IW = 4, TW = AW - OFS - IW;

  logic clk = 1'b0;
  logic rst_n;
  logic inq_strobe, inq_inv;
  logic [AW-1:0] inq_addr;
  logic rsp_valid, rsp_hit, rsp_hitm, busy;
  logic fill_en, fill_dside;
  logic [AW-1:0] fill_addr;
  logic [1:0] fill_state;
  logic wbuf_push;
  logic [AW-1:0] wbuf_addr;
  logic [NWB-1:0] wbuf_clr;
  logic wb_req_valid, wb_req_ready, wb_done;
  logic [AW-1:0] wb_req_addr;

  always #2.5 clk = ~clk;

  inq_snoop_responder #(.AW(AW), .OFS_W(OFS), .SETS(SETS), .NWB(NWB)) i_inq_snoop_responder (
    .clk(clk), .rst_n(rst_n),
    .inq_strobe(inq_strobe), .inq_addr(inq_addr), .inq_inv(inq_inv),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_hitm(rsp_hitm), .busy(busy),
    .fill_en(fill_en), .fill_dside(fill_dside), .fill_addr(fill_addr), .fill_state(fill_state),
    .wbuf_push(wbuf_push), .wbuf_addr(wbuf_addr), .wbuf_clr(wbuf_clr),
    .wb_req_valid(wb_req_valid), .wb_req_ready(wb_req_ready),
    .wb_req_addr(wb_req_addr), .wb_done(wb_done)
  );

  typedef struct { logic h; logic hm; string req; } exp_t;
  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0;

  task automatic check_eq(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(input logic [TW-1:0] t, input logic [IW-1:0] i,
                                       input logic [OFS-1:0] o);
    return {t, i, o};
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && rsp_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R8 unexpected response: actual 1 expected 0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check_eq(e.req, "rsp_hit", rsp_hit, e.h);
        check_eq(e.req, "rsp_hitm", rsp_hitm, e.hm);
      end
    end
  end

  task automatic fill(input logic dside, input logic [AW-1:0] a, input logic [1:0] st);
    @(negedge clk);
    fill_en = 1; fill_dside = dside; fill_addr = a; fill_state = st;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic push_wb(input logic [AW-1:0] a);
    @(negedge clk);
    wbuf_push = 1; wbuf_addr = a;
    @(negedge clk);
    wbuf_push = 0;
  endtask

  task automatic clr_wb(input logic [NWB-1:0] m);
    @(negedge clk);
    wbuf_clr = m;
    @(negedge clk);
    wbuf_clr = '0;
  endtask

  task automatic inquire(input logic [AW-1:0] a, input logic inv, input logic eh,
                         input logic ehm, input string req, input bit col = 0,
                         input logic [AW-1:0] caddr = '0, input logic [1:0] cst = 2'b00);
    @(negedge clk);
    while (busy) @(negedge clk);
    inq_addr = a; inq_inv = inv; inq_strobe = 1;
    exp_q.push_back('{eh, ehm, req});
    @(negedge clk);
    inq_strobe = 0;
    check_eq("R1", "no response one cycle after strobe", rsp_valid, 0);
    if (col) begin
      fill_en = 1; fill_dside = 1; fill_addr = caddr; fill_state = cst;
    end
    @(negedge clk);
    fill_en = 0;
    check_eq("R1", "response two cycles after strobe", rsp_valid, 1);
  endtask

  // call right after an inquire that expects hit-modified
  task automatic serve(input logic [AW-1:0] exp_addr);
    check_eq("R6", "wb_req_valid raised", wb_req_valid, 1);
    check_eq("R6", "wb_req_addr", wb_req_addr, exp_addr);
    inq_strobe = 1; inq_addr = exp_addr; inq_inv = 1;
    check_eq("R8", "busy while writeback pending", busy, 1);
    @(negedge clk);
    inq_strobe = 0;
    check_eq("R6", "request held without ready", wb_req_valid, 1);
    check_eq("R6", "address held without ready", wb_req_addr, exp_addr);
    wb_done = 1;
    @(negedge clk);
    wb_done = 0;
    check_eq("R6", "early done ignored, request", wb_req_valid, 1);
    check_eq("R6", "early done ignored, hitm", rsp_hitm, 1);
    wb_req_ready = 1;
    @(negedge clk);
    wb_req_ready = 0;
    check_eq("R6", "request dropped after ready", wb_req_valid, 0);
    check_eq("R7", "hitm held after handshake", rsp_hitm, 1);
    @(negedge clk);
    check_eq("R7", "hitm held before done", rsp_hitm, 1);
    check_eq("R8", "busy before done", busy, 1);
    wb_done = 1;
    @(negedge clk);
    wb_done = 0;
    check_eq("R7", "hitm cleared by done", rsp_hitm, 0);
    check_eq("R8", "busy cleared by done", busy, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; inq_strobe = 0; inq_inv = 0; inq_addr = '0;
    fill_en = 0; fill_dside = 0; fill_addr = '0; fill_state = 2'b00;
    wbuf_push = 0; wbuf_addr = '0; wbuf_clr = '0;
    wb_req_ready = 0; wb_done = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_eq("R11", "rsp_valid after reset", rsp_valid, 0);
    check_eq("R11", "rsp_hit after reset", rsp_hit, 0);
    check_eq("R11", "rsp_hitm after reset", rsp_hitm, 0);
    check_eq("R11", "busy after reset", busy, 0);
    check_eq("R11", "wb_req_valid after reset", wb_req_valid, 0);
    inquire(mk(5, 3, 0), 0, 0, 0, "R11");

    // data line exclusive -> shared -> invalid
    fill(1, mk(5, 3, 0), 2'b10);
    inquire(mk(5, 3, 7), 0, 1, 0, "R2");
    inquire(mk(5, 3, 0), 0, 1, 0, "R4");
    inquire(mk(5, 3, 0), 1, 1, 0, "R5");
    inquire(mk(5, 3, 0), 0, 0, 0, "R5");

    // tag mismatch in an occupied set
    fill(1, mk(9, 4, 0), 2'b01);
    inquire(mk(8, 4, 0), 0, 0, 0, "R2");

    // instruction line
    fill(0, mk(6, 2, 0), 2'b01);
    inquire(mk(6, 2, 4), 0, 1, 0, "R2");
    inquire(mk(6, 2, 4), 0, 1, 0, "R4");
    inquire(mk(6, 2, 4), 1, 1, 0, "R5");
    inquire(mk(6, 2, 4), 0, 0, 0, "R5");

    // modified data line, qualifier low
    fill(1, mk(7, 6, 0), 2'b11);
    inquire(mk(7, 6, 9), 0, 0, 1, "R3");
    serve(mk(7, 6, 0));
    inquire(mk(7, 6, 0), 0, 1, 0, "R7");

    // modified data line, qualifier high
    fill(1, mk(2, 7, 0), 2'b11);
    inquire(mk(2, 7, 0), 1, 0, 1, "R3");
    serve(mk(2, 7, 0));
    inquire(mk(2, 7, 0), 0, 0, 0, "R7");

    // both caches hold the line
    fill(1, mk(3, 8, 0), 2'b11);
    fill(0, mk(3, 8, 0), 2'b01);
    inquire(mk(3, 8, 0), 1, 0, 1, "R3");
    serve(mk(3, 8, 0));
    inquire(mk(3, 8, 0), 0, 0, 0, "R5");

    // writeback buffer hit
    push_wb(mk(4, 9, 0));
    inquire(mk(4, 9, 16), 0, 0, 1, "R3");
    serve(mk(4, 9, 0));
    inquire(mk(4, 9, 0), 0, 0, 0, "R7");

    // buffer full, drop, release
    for (int k = 0; k < 5; k++) push_wb(mk(TW'(10 + k), 1, 0));
    inquire(mk(14, 1, 0), 0, 0, 0, "R10");
    clr_wb(4'b0001);
    inquire(mk(10, 1, 0), 0, 0, 0, "R10");
    inquire(mk(11, 1, 0), 1, 0, 1, "R10");
    serve(mk(11, 1, 0));
    clr_wb(4'b1111);
    inquire(mk(13, 1, 0), 0, 0, 0, "R10");

    // fill collides with the snoop update
    fill(1, mk(20, 11, 0), 2'b01);
    inquire(mk(20, 11, 0), 1, 1, 0, "R9", 1, mk(21, 11, 0), 2'b10);
    inquire(mk(21, 11, 0), 0, 1, 0, "R9");
    inquire(mk(20, 11, 0), 0, 0, 0, "R9");

    repeat (3) @(negedge clk);
    check_eq("R1", "all expected responses seen", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule